// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block turns the switch commands for a full H-bridge into four gate enables. The bridge is split into two half-bridges, A and B. Each half has a low-side command, a high-side command and a flag that reports a low high-side bootstrap supply. It drives one low-side and one high-side gate enable. A global disable input and a supply undervoltage flag shut the whole bridge off. Inside a half, the low-side command wins over the high-side command, so the two switches of one leg are never requested together.

Every gate enable has its own down-counter. A turn-on waits a programmable number of clock cycles (`dead_cycles`) before it reaches the pin. A turn-off reaches the pin at the next clock edge. This creates a guaranteed gap between one switch of a leg opening and the other one closing. If a half's high-side command is held high, its low-side command alone switches the leg in a complementary way, and the gap is inserted at every transition.

The bridge can leave the blocked state after disable, after undervoltage or after reset. When it does, both low-side gates give a bootstrap refresh pulse whose length is a fixed number of cycles. The high-side gates are then held off for a longer fixed number of cycles.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While `dis` is 1 at a clock edge, all four gate enables are 0 after that edge, whatever the other inputs are.
- R2: While `vdd_uv` is 1 at a clock edge, all four gate enables are 0 after that edge.
- R3: A half's bootstrap flag (`x_hs_uv` = 1) holds only that half's high-side gate at 0. Its low-side gate still follows its low-side command.
- R4: Inside a half, a low-side command of 1 turns the low-side gate on and keeps the high-side gate off, even when the high-side command is also 1. The two gates of one half are never 1 together.
- R5: A half with both commands at 0 has both gates at 0.
- R6: A gate turns off at the first clock edge that samples its request gone. This is one cycle after the input change, with no dead time.
- R7: A gate turns on `dead_cycles` cycles later than a turn-off would. So it is first 1 after the (`dead_cycles`+1)-th edge that samples its request present. `dead_cycles` is an unsigned cycle count, and 0 means no added delay.
- R8: With the high-side command held at 1, the low-side command alone drives the half in a complementary way. On each transition the outgoing gate drops after 1 cycle and the incoming gate rises after `dead_cycles`+1 cycles.
- R9: Edge k = 0, 1, … is the k-th edge that samples the bridge unblocked after a blocked period. Both low-side gates are requested for edges 0 to REFRESH_CYC-1, whatever the commands are. With `dead_cycles` < REFRESH_CYC, this gives a pulse visible after edges `dead_cycles` to REFRESH_CYC-1.
- R10: After a blocked period, no high-side gate is requested before edge HOLDOFF_CYC. With its command held, a high-side gate first shows 1 after edge HOLDOFF_CYC+`dead_cycles`.
- R11: Reset acts as a blocked period. All gates are 0 during reset, and the refresh and hold-off sequence of R9 and R10 runs after reset is released.
- R12: A command pulse lasting fewer than `dead_cycles`+1 cycles never reaches its gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, acts like disable |
| dis | input | 1 | Global disable, 1 = all gates off |
| vdd_uv | input | 1 | Supply undervoltage flag, 1 = all gates off |
| dead_cycles | input | DT_W | Turn-on delay in clock cycles |
| a_lo_cmd | input | 1 | Half A low-side command |
| a_hi_cmd | input | 1 | Half A high-side command |
| a_hs_uv | input | 1 | Half A bootstrap undervoltage flag |
| b_lo_cmd | input | 1 | Half B low-side command |
| b_hi_cmd | input | 1 | Half B high-side command |
| b_hs_uv | input | 1 | Half B bootstrap undervoltage flag |
| a_lo_gate | output | 1 | Half A low-side gate enable |
| a_hi_gate | output | 1 | Half A high-side gate enable |
| b_lo_gate | output | 1 | Half B low-side gate enable |
| b_hi_gate | output | 1 | Half B high-side gate enable |

## Verification
The assertions check on every cycle the properties that hold at all times:
- the gates of a half are never on together;
- a block or bootstrap flag is followed by off gates;
- a withdrawn request is followed by an off gate;
- the refresh window never overlaps the high-side release.

Only the bench scenarios can show the exact number of cycles a turn-on takes, the shape and position of the refresh pulse, the hold-off length after disable or reset, and the filtering of short pulses. The bench does this by sweeping every input combination and several dead-time values and comparing the result against cycle counts it computes itself.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    // Command bundle for one half-bridge
    typedef struct packed {
        logic lo;
        logic hi;
        logic hs_uv;
    } half_cmd_t;

    // Gate pair for one half-bridge
    typedef struct packed {
        logic lo;
        logic hi;
    } half_gate_t;

    localparam int unsigned NUM_HALVES = 2;

endpackage

// File: rtl/hbg_ontimer.sv
// Per-gate turn-on delay: reload on a new request, clear on withdrawal.
module hbg_ontimer #(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DT_W-1:0] dead,
    input  logic            req,
    output logic            on
);

    typedef struct packed {
        logic [DT_W-1:0] cnt;
        logic            req;
        logic            on;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = req;
        if (!req) begin
            st_d.cnt = '0;
            st_d.on  = 1'b0;
        end else if (!st_q.req) begin
            st_d.cnt = dead;
            st_d.on  = (dead == '0);
        end else begin
            st_d.cnt = (st_q.cnt != '0) ? st_q.cnt - 1'b1 : '0;
            st_d.on  = (st_d.cnt == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign on = st_q.on;

    AST_OFF_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !on); // R6

endmodule

// File: rtl/hbg_wake.sv
// Tracks cycles since the bridge was unblocked: refresh window and hold-off.
module hbg_wake #(
    parameter int unsigned REFRESH_CYC = 16,
    parameter int unsigned HOLDOFF_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blk,
    output logic refresh,
    output logic hs_ok
);

    localparam int unsigned WK_W = $clog2(HOLDOFF_CYC + 1);
    localparam logic [WK_W-1:0] REF_END = WK_W'(REFRESH_CYC);
    localparam logic [WK_W-1:0] HO_END  = WK_W'(HOLDOFF_CYC);

    typedef struct packed {
        logic [WK_W-1:0] cnt;
    } wake_t;

    wake_t wk_d, wk_q;

    always_comb begin
        wk_d = wk_q;
        if (blk)                  wk_d.cnt = '0;
        else if (wk_q.cnt != HO_END) wk_d.cnt = wk_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

    assign refresh = !blk && (wk_q.cnt < REF_END);
    assign hs_ok   = !blk && (wk_q.cnt == HO_END);

    AST_REFRESH_BEFORE_HS: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |-> !hs_ok); // R10

endmodule

// File: rtl/hbg_half.sv
// One half-bridge: priority, gating and two turn-on timers.
module hbg_half
    import hbg_pkg::*;
#(
    parameter int unsigned DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DT_W-1:0] dead,
    input  logic            blk,
    input  logic            refresh,
    input  logic            hs_ok,
    input  half_cmd_t       cmd,
    output half_gate_t      gate
);

    logic lo_req, hi_req;

    always_comb begin
        lo_req = !blk && (cmd.lo || refresh);
        hi_req = !blk && hs_ok && !cmd.hs_uv && cmd.hi && !cmd.lo;
    end

    hbg_ontimer #(.DT_W(DT_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .dead(dead), .req(lo_req), .on(gate.lo)
    );

    hbg_ontimer #(.DT_W(DT_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .dead(dead), .req(hi_req), .on(gate.hi)
    );

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate.lo && gate.hi)); // R4

    AST_HS_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.hs_uv |=> !gate.hi); // R3

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int unsigned DT_W        = 8,
    parameter int unsigned REFRESH_CYC = 16,
    parameter int unsigned HOLDOFF_CYC = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dis,
    input  logic            vdd_uv,
    input  logic [DT_W-1:0] dead_cycles,
    input  logic            a_lo_cmd,
    input  logic            a_hi_cmd,
    input  logic            a_hs_uv,
    input  logic            b_lo_cmd,
    input  logic            b_hi_cmd,
    input  logic            b_hs_uv,
    output logic            a_lo_gate,
    output logic            a_hi_gate,
    output logic            b_lo_gate,
    output logic            b_hi_gate
);

    logic       blk;
    logic       refresh;
    logic       hs_ok;
    half_cmd_t  cmds  [NUM_HALVES];
    half_gate_t gates [NUM_HALVES];

    assign blk = dis || vdd_uv;

    assign cmds[0] = '{lo: a_lo_cmd, hi: a_hi_cmd, hs_uv: a_hs_uv};
    assign cmds[1] = '{lo: b_lo_cmd, hi: b_hi_cmd, hs_uv: b_hs_uv};

    hbg_wake #(.REFRESH_CYC(REFRESH_CYC), .HOLDOFF_CYC(HOLDOFF_CYC)) u_wake (
        .clk(clk), .rst_n(rst_n), .blk(blk), .refresh(refresh), .hs_ok(hs_ok)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        hbg_half #(.DT_W(DT_W)) u_half (
            .clk(clk), .rst_n(rst_n), .dead(dead_cycles), .blk(blk),
            .refresh(refresh), .hs_ok(hs_ok), .cmd(cmds[h]), .gate(gates[h])
        );
    end

    assign a_lo_gate = gates[0].lo;
    assign a_hi_gate = gates[0].hi;
    assign b_lo_gate = gates[1].lo;
    assign b_hi_gate = gates[1].hi;

    initial begin
        AST_PARAM_ORDER: assert (REFRESH_CYC < HOLDOFF_CYC); // R10
    end

    AST_DIS_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> !(a_lo_gate || a_hi_gate || b_lo_gate || b_hi_gate)); // R1

    AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_uv |=> !(a_lo_gate || a_hi_gate || b_lo_gate || b_hi_gate)); // R2

    AST_HS_NEEDS_UNBLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hi_gate || b_hi_gate) |-> !$past(blk)); // R10

endmodule

// File: tb/tb_hbridge_gate_ctrl.sv
module tb_hbridge_gate_ctrl;

    localparam int RC = 16;
    localparam int HC = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dis = 1'b0, vdd_uv = 1'b0;
    logic [7:0] dead_cycles = 8'd2;
    logic a_lo_cmd = 0, a_hi_cmd = 1, a_hs_uv = 0;
    logic b_lo_cmd = 0, b_hi_cmd = 1, b_hs_uv = 0;
    logic a_lo_gate, a_hi_gate, b_lo_gate, b_hi_gate;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hbridge_gate_ctrl #(.DT_W(8), .REFRESH_CYC(RC), .HOLDOFF_CYC(HC)) dut (
        .clk(clk), .rst_n(rst_n), .dis(dis), .vdd_uv(vdd_uv),
        .dead_cycles(dead_cycles),
        .a_lo_cmd(a_lo_cmd), .a_hi_cmd(a_hi_cmd), .a_hs_uv(a_hs_uv),
        .b_lo_cmd(b_lo_cmd), .b_hi_cmd(b_hi_cmd), .b_hs_uv(b_hs_uv),
        .a_lo_gate(a_lo_gate), .a_hi_gate(a_hi_gate),
        .b_lo_gate(b_lo_gate), .b_hi_gate(b_hi_gate)
    );

    function automatic logic [3:0] gates();
        return {b_hi_gate, b_lo_gate, a_hi_gate, a_lo_gate};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count negedges until gate idx equals val
    task automatic lat(input int idx, input logic val, output int n);
        logic [3:0] g;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            n++;
            g = gates();
            if (g[idx] == val) break;
        end
    endtask

    // Released from blocked with low cmds 0 and high cmds 1
    task automatic wake_seq(input string tag, input int d);
        for (int k = 1; k <= HC + d + 3; k++) begin
            @(negedge clk);
            chk({tag, " refresh low A R9"}, a_lo_gate, ((k-1) >= d && (k-1) <= RC-1) ? 1 : 0);
            chk({tag, " refresh low B R9"}, b_lo_gate, ((k-1) >= d && (k-1) <= RC-1) ? 1 : 0);
            chk({tag, " holdoff high A R10"}, a_hi_gate, ((k-1) >= HC + d) ? 1 : 0);
            chk({tag, " holdoff high B R10"}, b_hi_gate, ((k-1) >= HC + d) ? 1 : 0);
        end
    endtask

    initial begin
        int n;
        // R11: gates low during reset, then the wake sequence runs
        cycles(3);
        chk("reset state R11", gates(), 0);
        rst_n = 1'b1;
        wake_seq("after reset R11", 2);

        // Static sweep over every input combination
        for (int v = 0; v < 256; v++) begin
            logic [7:0] s;
            logic el_a, eh_a, el_b, eh_b;
            string tg;
            s = v[7:0];
            @(negedge clk);
            {dis, vdd_uv, a_lo_cmd, a_hi_cmd, a_hs_uv, b_lo_cmd, b_hi_cmd, b_hs_uv} = s;
            cycles(HC + 8);
            el_a = !s[7] && !s[6] && s[5];
            eh_a = !s[7] && !s[6] && !s[5] && s[4] && !s[3];
            el_b = !s[7] && !s[6] && s[2];
            eh_b = !s[7] && !s[6] && !s[2] && s[1] && !s[0];
            tg = s[7] ? "R1" : s[6] ? "R2" : (s[3] || s[0]) ? "R3" :
                 (s[5] || s[2]) ? "R4" : "R5";
            chk({"sweep ", tg}, gates(), {eh_b, el_b, eh_a, el_a});
        end

        // Dead-time latency and bistate operation for several settings
        for (int d = 0; d < 6; d += 1) begin
            @(negedge clk);
            dis = 1; vdd_uv = 0; dead_cycles = 8'(d);
            a_lo_cmd = 0; a_hi_cmd = 1; a_hs_uv = 0;
            b_lo_cmd = 0; b_hi_cmd = 1; b_hs_uv = 0;
            cycles(3);
            chk("dis holds gates off R1", gates(), 0);
            @(negedge clk);
            dis = 0;
            wake_seq("after disable", d);
            // Bistate: lo rises -> hi off in 1, lo on in d+1
            a_lo_cmd = 1;
            lat(1, 1'b0, n); chk("bistate hi off R8 R6", n, 1);
            cycles(0);
            n = 1;
            while (!a_lo_gate && n < 100) begin @(negedge clk); n++; end
            chk("bistate lo on R8 R7", n, d + 1);
            @(negedge clk);
            a_lo_cmd = 0;
            lat(0, 1'b0, n); chk("bistate lo off R8 R6", n, 1);
            n = 1;
            while (!a_hi_gate && n < 100) begin @(negedge clk); n++; end
            chk("bistate hi on R8 R7", n, d + 1);
            // Independent low-side on/off in half B with high cmd 0
            b_hi_cmd = 0;
            lat(3, 1'b0, n); chk("B hi off R6", n, 1);
            @(negedge clk);
            b_lo_cmd = 1;
            lat(2, 1'b1, n); chk("B lo on delay R7", n, d + 1);
            @(negedge clk);
            b_lo_cmd = 0;
            lat(2, 1'b0, n); chk("B lo off R6", n, 1);
            // Short pulse filter
            if (d > 0) begin
                int seen;
                seen = 0;
                @(negedge clk);
                b_lo_cmd = 1;
                for (int i = 0; i < d; i++) begin @(negedge clk); seen |= int'(b_lo_gate); end
                b_lo_cmd = 0;
                for (int i = 0; i < d + 3; i++) begin @(negedge clk); seen |= int'(b_lo_gate); end
                chk("short pulse dropped R12", seen, 0);
                b_lo_cmd = 1;
                seen = 0;
                for (int i = 0; i < d + 1; i++) begin @(negedge clk); seen |= int'(b_lo_gate); end
                chk("pulse of d+1 passes R12", seen, 1);
                b_lo_cmd = 0;
            end
            // Undervoltage blocks the whole bridge
            @(negedge clk);
            a_lo_cmd = 1; b_lo_cmd = 1;
            cycles(d + 3);
            vdd_uv = 1;
            @(negedge clk);
            chk("uv all off next edge R2", gates(), 0);
            vdd_uv = 0; a_lo_cmd = 0; b_lo_cmd = 0;
            cycles(HC + 10);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 190000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule